// File: doc/BRIEF.md
# External Bus Recovery-Cycle Inserter

This block sits between the arbiter that picks the next external-bus request and the engine that runs the bus cycle. A request names one of eight chip-select areas and says whether it is a read or a write. The block grants the request with a valid/ready handshake. It then drives that area's active-low chip select until the bus cycle engine pulses the completion strobe. After that it holds every chip select high for a recovery period, and then for one further idle cycle, before it grants the next access.

The recovery length depends on the previous access. After a write it is that area's write-recovery count, and after a read it is that area's read-recovery count. Recovery is inserted only when the direction or area changes: write then read, read then write, or read then read to another area. Write then write inserts none, and so does read then read to the same area. The idle cycle is always inserted.

Back-pressure rules: `req_valid` and the payload must stay stable until the handshake (`req_valid && req_ready` on a rising edge). `req_ready` may depend on the presented payload. It never rises while a chip select is low. A request that arrives during recovery is simply held until the gap is satisfied.

Top module: `busrec_gate`

## Requirements
- R1: Write after read. When a write follows a read, the chip selects stay all high for exactly RC+1 cycles between the two accesses, provided the request is already waiting. RC is the read-recovery count of the area that was read. Area i's count sits in bits [4i+3:4i] of `rd_rcv_cnt`.
- R2: Read after read to a different area. The gap is RC+1 cycles, where RC is the read-recovery count of the previous area, not of the new one.
- R3: Read after write. The gap is WC+1 cycles, where WC is the write-recovery count of the area that was written. Area i's count sits in bits [4i+3:4i] of `wr_rcv_cnt`. The maximum count of 15 gives a 16-cycle gap.
- R4: Write after write. No recovery is inserted, so a waiting write starts after exactly one all-high cycle.
- R5: Read after read to the same area. No recovery is inserted, so the gap is exactly one cycle.
- R6: A recovery count of zero gives the same single idle cycle as no recovery.
- R7: While the gap is not yet satisfied, `req_ready` stays low. When a valid request waits, `req_ready` is high exactly once the all-high time reaches the required recovery. A request that arrives after recovery has elapsed is granted at once.
- R8: During reset all chip selects are high. After reset there is no previous access, so the first access gets only the idle cycle.
- R9: After a handshake, only `cs_n[area]` goes low, starting on the next cycle. It stays low until the cycle after `cyc_done`. `cyc_done` has no effect while no chip select is low.
- R10: `req_ready` is low whenever any chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Grant; the access starts on the cycle after the handshake |
| req_area | input | 3 | Chip-select area of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| cyc_done | input | 1 | Single-cycle pulse marking the last cycle of the bus access |
| wr_rcv_cnt | input | 32 | Write-recovery count per area, 4 bits each |
| rd_rcv_cnt | input | 32 | Read-recovery count per area, 4 bits each |
| cs_n | output | 8 | Active-low chip selects, one per area |

## Verification
The handshake registers on the rising edge, so the chip select falls one cycle after it. The chip selects return high one cycle after the edge that samples `cyc_done`, and that first high cycle is counted as gap cycle zero. A waiting request is therefore granted in gap cycle RC, and the gap seen at the pins is RC+1 cycles.

Inputs are driven just after the falling edge. Outputs are sampled one time unit later, still in the low half of the clock. At each such sample the bench counts all-high cycles and compares `req_ready` with whether the required recovery has been reached. It then compares the total gap and the asserted chip select with values worked out from its own copy of the count tables.

// File: rtl/busrec_pkg.sv
package busrec_pkg;
  typedef enum logic {
    PH_REST = 1'b0,
    PH_BUSY = 1'b1
  } phase_t;

  typedef struct packed {
    logic seen;
    logic wr;
  } last_acc_t;
endpackage

// File: rtl/busrec_rule.sv
module busrec_rule #(
  parameter int AREAS  = 8,
  parameter int CNT_W  = 4,
  localparam int AREA_W = $clog2(AREAS)
) (
  input  busrec_pkg::last_acc_t     last_acc,
  input  logic [AREA_W-1:0]         last_area,
  input  logic [AREA_W-1:0]         req_area,
  input  logic                      req_write,
  input  logic [AREAS*CNT_W-1:0]    wr_tab,
  input  logic [AREAS*CNT_W-1:0]    rd_tab,
  output logic [CNT_W-1:0]          need
);
  logic [CNT_W-1:0] wr_arr [AREAS];
  logic [CNT_W-1:0] rd_arr [AREAS];

  for (genvar g = 0; g < AREAS; g++) begin : g_unpack
    assign wr_arr[g] = wr_tab[g*CNT_W +: CNT_W];
    assign rd_arr[g] = rd_tab[g*CNT_W +: CNT_W];
  end

  always_comb begin
    need = '0;
    if (last_acc.seen) begin
      if (last_acc.wr) begin
        if (!req_write) need = wr_arr[last_area];
      end else if (req_write || (req_area != last_area)) begin
        need = rd_arr[last_area];
      end
    end
  end
endmodule

// File: rtl/busrec_timer.sv
module busrec_timer #(
  parameter int CNT_W = 4,
  localparam int GAP_W = CNT_W + 1,
  localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(1 << CNT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  output logic [GAP_W-1:0] gap
);
  always_ff @(posedge clk) begin
    if (!rst_n)             gap <= '0;
    else if (hold)          gap <= '0;
    else if (gap != GAP_TOP) gap <= gap + 1'b1;
  end
endmodule

// File: rtl/busrec_seq.sv
module busrec_seq #(
  parameter int AREAS  = 8,
  localparam int AREA_W = $clog2(AREAS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  grant,
  input  logic [AREA_W-1:0]     req_area,
  input  logic                  req_write,
  input  logic                  cyc_done,
  output busrec_pkg::phase_t    phase,
  output busrec_pkg::last_acc_t last_acc,
  output logic [AREA_W-1:0]     last_area,
  output logic [AREAS-1:0]      cs_n
);
  import busrec_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_REST;
      last_acc  <= '0;
      last_area <= '0;
    end else begin
      case (phase)
        PH_REST: if (grant) begin
          phase         <= PH_BUSY;
          last_acc.seen <= 1'b1;
          last_acc.wr   <= req_write;
          last_area     <= req_area;
        end
        PH_BUSY: if (cyc_done) phase <= PH_REST;
        default: phase <= PH_REST;
      endcase
    end
  end

  for (genvar g = 0; g < AREAS; g++) begin : g_cs
    assign cs_n[g] = !((phase == PH_BUSY) && (last_area == AREA_W'(g)));
  end
endmodule

// File: rtl/busrec_gate.sv
module busrec_gate #(
  parameter int AREAS  = 8,
  parameter int CNT_W  = 4,
  localparam int AREA_W = $clog2(AREAS),
  localparam int GAP_W  = CNT_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [AREA_W-1:0]      req_area,
  input  logic                   req_write,
  input  logic                   cyc_done,
  input  logic [AREAS*CNT_W-1:0] wr_rcv_cnt,
  input  logic [AREAS*CNT_W-1:0] rd_rcv_cnt,
  output logic [AREAS-1:0]       cs_n
);
  import busrec_pkg::*;

  phase_t            phase;
  last_acc_t         last_acc;
  logic [AREA_W-1:0] last_area;
  logic [CNT_W-1:0]  need;
  logic [GAP_W-1:0]  gap;
  logic              grant;

  busrec_rule #(.AREAS(AREAS), .CNT_W(CNT_W)) u_rule (
    .last_acc (last_acc),
    .last_area(last_area),
    .req_area (req_area),
    .req_write(req_write),
    .wr_tab   (wr_rcv_cnt),
    .rd_tab   (rd_rcv_cnt),
    .need     (need)
  );

  busrec_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (phase == PH_BUSY),
    .gap  (gap)
  );

  assign req_ready = (phase == PH_REST) && (gap >= {1'b0, need});
  assign grant     = req_valid && req_ready;

  busrec_seq #(.AREAS(AREAS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .req_area (req_area),
    .req_write(req_write),
    .cyc_done (cyc_done),
    .phase    (phase),
    .last_acc (last_acc),
    .last_area(last_area),
    .cs_n     (cs_n)
  );
endmodule

// File: rtl/busrec_gate_chk.sv
module busrec_gate_chk #(
  parameter int AREAS  = 8,
  localparam int AREA_W = $clog2(AREAS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [AREA_W-1:0] req_area,
  input logic              cyc_done,
  input logic [AREAS-1:0]  cs_n
);
  logic any_low;
  assign any_low = (cs_n != '1);

  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r10_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    any_low |-> !req_ready);

  a_r9_select_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cs_n == ~(AREAS'(1) << $past(req_area))));

  a_r9_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (any_low && cyc_done) |=> (cs_n == '1));

  a_r9_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (any_low && !cyc_done) |=> $stable(cs_n));

  a_r8_reset_high: assert property (@(posedge clk)
    !rst_n |=> (cs_n == '1));
endmodule

bind busrec_gate busrec_gate_chk #(.AREAS(AREAS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_area (req_area),
  .cyc_done (cyc_done),
  .cs_n     (cs_n)
);

// File: tb/busrec_gate_bench.sv
`timescale 1ns/1ps
module busrec_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_area = '0;
  logic        req_write = 1'b0;
  logic        cyc_done = 1'b0;
  logic [31:0] wr_rcv_cnt;
  logic [31:0] rd_rcv_cnt;
  logic [7:0]  cs_n;

  int vectors = 0;
  int misses  = 0;
  int wr_tab [8];
  int rd_tab [8];

  always #5 clk = ~clk;

  busrec_gate u_busrec_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_area  (req_area),
    .req_write (req_write),
    .cyc_done  (cyc_done),
    .wr_rcv_cnt(wr_rcv_cnt),
    .rd_rcv_cnt(rd_rcv_cnt),
    .cs_n      (cs_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // One access: optional idle wait, request, grant wait, busy, completion.
  task automatic run_access(input string tag, input int area, input bit wr,
                            input int need, input int prewait,
                            input int busy_len, input bit spurious);
    int gap = 0;
    int exp_gap;
    bit rdy_ok = 1'b1;
    exp_gap = ((prewait > need) ? prewait : need) + 1;
    for (int k = 0; k < prewait; k++) begin
      if (cs_n != 8'hFF) rdy_ok = 1'b0;
      gap++;
      step();
    end
    req_valid = 1'b1;
    req_area  = 3'(area);
    req_write = wr;
    #0.1;
    while (cs_n == 8'hFF && gap < 60) begin
      cyc_done = (spurious && gap == 1);
      #0.1;
      if (req_ready != (gap >= need)) rdy_ok = 1'b0;
      gap++;
      step();
      cyc_done = 1'b0;
    end
    req_valid = 1'b0;
    check({tag, " R7 ready timing"}, rdy_ok, 1);
    check({tag, " gap"}, gap, exp_gap);
    check({tag, " R9 select"}, cs_n, int'(8'hFF & ~(8'h01 << area)));
    check({tag, " R10 no ready in access"}, req_ready, 0);
    for (int k = 1; k < busy_len; k++) begin
      step();
      check({tag, " R9 held low"}, cs_n, int'(8'hFF & ~(8'h01 << area)));
    end
    cyc_done = 1'b1;
    step();
    cyc_done = 1'b0;
    check({tag, " R9 release"}, cs_n, 8'hFF);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      rd_tab[i] = (i == 7) ? 0 : i + 1;
      wr_tab[i] = (i == 7) ? 15 : 8 - i;
      rd_rcv_cnt[i*4 +: 4] = 4'(rd_tab[i]);
      wr_rcv_cnt[i*4 +: 4] = 4'(wr_tab[i]);
    end
    repeat (3) step();
    check("R8 reset cs high", cs_n, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    run_access("R8 first read a2",        2, 1'b0, 0,         0, 2, 1'b0);
    run_access("R5 read a2 after read a2", 2, 1'b0, 0,         0, 1, 1'b0);
    run_access("R2 read a5 after read a2", 5, 1'b0, rd_tab[2], 0, 3, 1'b0);
    run_access("R1 write a3 after read a5",3, 1'b1, rd_tab[5], 0, 2, 1'b0);
    run_access("R4 write a1 after write",  1, 1'b1, 0,         0, 1, 1'b0);
    run_access("R3 read a1 after write a1",1, 1'b0, wr_tab[1], 0, 2, 1'b0);
    run_access("R9 stray done, R1 wr a7",  7, 1'b1, rd_tab[1], 0, 1, 1'b1);
    run_access("R3 max count, read a0",    0, 1'b0, wr_tab[7], 0, 2, 1'b0);
    run_access("R2 read a7 after read a0", 7, 1'b0, rd_tab[0], 0, 1, 1'b0);
    run_access("R6 zero count, read a4",   4, 1'b0, rd_tab[7], 0, 3, 1'b0);
    run_access("R7 late write a6",         6, 1'b1, rd_tab[4], 10, 1, 1'b0);
    run_access("R7 held write a6 after wr",6, 1'b1, 0,         0, 2, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #100000;
    misses++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule